// File: doc/BRIEF.md
# Four-Channel LED Blink Controller

This block is a register-configured bus slave that drives four LED outputs. Each LED has its own control word. The word selects whether the LED is dark, steadily lit, or blinking. For blinking, it also gives a half-period, the number of timer ticks the LED spends in each phase. A host agent writes and reads the control words over a simple strobe/acknowledge register bus.

The timer tick comes from a prescaler that divides the system clock. The clock and tick frequencies are elaboration parameters, and the divide ratio is their quotient. A further parameter chooses whether a lit LED drives its pin high or low. Writing any control word restarts that LED's blink sequence, so a new setting takes effect from a known phase.

Top module: `led_blink_client`

## Requirements
- R1: While reset is held and right after it is released, every LED is inactive, the acknowledge is low, and every control word reads back as zero.
- R2: A strobe seen while the acknowledge is low produces an acknowledge on the following cycle. The acknowledge lasts exactly one cycle, and it never appears without a strobe on the cycle before.
- R3: The address selects LED 0 to 3. A control word holds the mode in bits [1:0] and the half-period in bits [31:16]. A read returns exactly these fields, with bits [15:2] reading as zero. Read data is valid in the cycle the acknowledge is high.
- R4: Mode 01 makes the LED steadily active.
- R5: Modes 00 and 11 keep the LED inactive.
- R6: Mode 10 blinks the LED. Starting from the write, the LED is inactive. It toggles on the clock edge that consumes the N-th tick after the write and on every N-th tick after that, where N is the half-period.
- R7: A half-period of 0 blinks exactly like a half-period of 1.
- R8: A write to a control word clears that LED's tick count and returns it to the inactive phase, even when the written value equals the stored one.
- R9: The tick recurs every CLK_FREQ_HZ / TICK_FREQ_HZ cycles and counts from reset. With a half-period of 1, a blinking LED toggles exactly that often.
- R10: With ACTIVE_HIGH = 0, every LED output is the inverse of the output the same configuration gives with ACTIVE_HIGH = 1.
- R11: A write to one LED does not alter the state or blink timing of any other LED.
- R12: A read leaves every control word and every blink sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| bus_adr_i | input | 2 | LED index of the control word accessed |
| bus_dat_i | input | 32 | Write data |
| bus_we_i | input | 1 | 1 for a write, 0 for a read |
| bus_stb_i | input | 1 | Transfer request |
| bus_ack_o | output | 1 | Transfer acknowledge, one cycle |
| bus_dat_o | output | 32 | Read data, valid with the acknowledge |
| led_o | output | 4 | LED drive, polarity set by ACTIVE_HIGH |

## Verification
The bench counts clock edges after reset. A transfer whose strobe is sampled at edge W is due to show its acknowledge and read data at the sample after edge W, and at no other time. The driver queues each transfer with that due edge, and the monitor pops the entry and compares cycle and data.

A write also restarts its LED at edge W. The toggles then fall on the edges that consume the N-th, 2N-th and later ticks, where ticks are the edges whose count is a multiple of the divide ratio. The monitor compares all four LEDs of both polarity variants in every cycle against this closed-form count. All sampling happens on the falling edge, half a period after the registers change.

// File: rtl/led_blink_pkg.sv
package led_blink_pkg;

    localparam int LED_COUNT = 4;
    localparam int ADR_W     = $clog2(LED_COUNT);
    localparam int DATA_W    = 32;
    localparam int HALF_W    = 16;
    localparam int HALF_LSB  = DATA_W - HALF_W;

    typedef enum logic [1:0] {
        LED_OFF   = 2'b00,
        LED_ON    = 2'b01,
        LED_BLINK = 2'b10,
        LED_RSVD  = 2'b11
    } led_mode_e;

    typedef struct packed {
        logic [HALF_W-1:0] half;
        led_mode_e         mode;
    } led_cfg_t;

    function automatic led_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        led_cfg_t c;
        c.mode = led_mode_e'(w[1:0]);
        c.half = w[DATA_W-1:HALF_LSB];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input led_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[1:0] = c.mode;
        w[DATA_W-1:HALF_LSB] = c.half;
        return w;
    endfunction

    function automatic logic [HALF_W:0] eff_half(input logic [HALF_W-1:0] h);
        return (h == '0) ? {{HALF_W{1'b0}}, 1'b1} : {1'b0, h};
    endfunction

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_every
            assign tick_o = 1'b1;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick_o = (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
    import led_blink_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic [ADR_W-1:0]    adr_i,
    input  logic [DATA_W-1:0]   dat_i,
    input  logic                we_i,
    input  logic                stb_i,
    output logic                ack_o,
    output logic [DATA_W-1:0]   dat_o,
    output led_cfg_t            cfg_o [LED_COUNT],
    output logic [LED_COUNT-1:0] wr_hit_o
);
    logic accept;
    logic unused_bits;

    assign accept      = stb_i & ~ack_o;
    assign unused_bits = ^dat_i[HALF_LSB-1:2];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ack_o <= 1'b0;
            dat_o <= '0;
            for (int i = 0; i < LED_COUNT; i++) begin
                cfg_o[i] <= '0;
            end
        end else begin
            ack_o <= accept;
            dat_o <= (accept && !we_i) ? cfg_to_word(cfg_o[adr_i]) : '0;
            if (accept && we_i) begin
                cfg_o[adr_i] <= word_to_cfg(dat_i);
            end
        end
    end

    generate
        for (genvar g = 0; g < LED_COUNT; g++) begin : g_hit
            assign wr_hit_o[g] = accept & we_i & (adr_i == ADR_W'(g));
        end
    endgenerate
endmodule

// File: rtl/led_blink_lane.sv
module led_blink_lane
    import led_blink_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_i,
    input  logic     tick_i,
    input  logic     restart_i,
    input  led_cfg_t cfg_i,
    output logic     lit_o
);
    logic [HALF_W:0]   limit;
    logic [HALF_W-1:0] cnt;
    logic              phase;

    assign limit = eff_half(cfg_i.half);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (restart_i) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cfg_i.mode == LED_BLINK && tick_i) begin
            if ({1'b0, cnt} + 1'b1 >= limit) begin
                cnt   <= '0;
                phase <= ~phase;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (cfg_i.mode)
            LED_ON:    lit_o = 1'b1;
            LED_BLINK: lit_o = phase;
            default:   lit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_blink_client.sv
module led_blink_client
    import led_blink_pkg::*;
#(
    parameter int CLK_FREQ_HZ  = 100_000_000,
    parameter int TICK_FREQ_HZ = 1_000,
    parameter bit ACTIVE_HIGH  = 1'b1
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [ADR_W-1:0]     bus_adr_i,
    input  logic [DATA_W-1:0]    bus_dat_i,
    input  logic                 bus_we_i,
    input  logic                 bus_stb_i,
    output logic                 bus_ack_o,
    output logic [DATA_W-1:0]    bus_dat_o,
    output logic [LED_COUNT-1:0] led_o
);
    localparam int RATIO    = CLK_FREQ_HZ / TICK_FREQ_HZ;
    localparam int TICK_DIV = (RATIO < 1) ? 1 : RATIO;

    logic                 tick;
    led_cfg_t             cfg [LED_COUNT];
    logic [LED_COUNT-1:0] wr_hit;
    logic [LED_COUNT-1:0] lit;

    led_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .tick_o (tick)
    );

    led_cfg_regs u_regs (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .adr_i    (bus_adr_i),
        .dat_i    (bus_dat_i),
        .we_i     (bus_we_i),
        .stb_i    (bus_stb_i),
        .ack_o    (bus_ack_o),
        .dat_o    (bus_dat_o),
        .cfg_o    (cfg),
        .wr_hit_o (wr_hit)
    );

    generate
        for (genvar g = 0; g < LED_COUNT; g++) begin : g_lane
            led_blink_lane u_lane (
                .clk_i     (clk_i),
                .rst_i     (rst_i),
                .tick_i    (tick),
                .restart_i (wr_hit[g]),
                .cfg_i     (cfg[g]),
                .lit_o     (lit[g])
            );
        end

        if (ACTIVE_HIGH) begin : g_pos
            assign led_o = lit;
        end else begin : g_neg
            assign led_o = ~lit;
        end
    endgenerate
endmodule

// File: rtl/led_blink_client_chk.sv
module led_blink_client_chk
    import led_blink_pkg::*;
#(
    parameter int TICK_DIV    = 4,
    parameter bit ACTIVE_HIGH = 1'b1
) (
    input logic                 clk_i,
    input logic                 rst_i,
    input logic                 bus_stb_i,
    input logic                 bus_ack_o,
    input logic                 tick,
    input led_cfg_t             cfg [LED_COUNT],
    input logic [LED_COUNT-1:0] wr_hit,
    input logic [LED_COUNT-1:0] led_o
);
    int gap;

    always_ff @(posedge clk_i) begin
        if (rst_i || tick) gap <= 0;
        else               gap <= gap + 1;
    end

    // R2
    ack_follows_stb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (bus_stb_i && !bus_ack_o) |=> bus_ack_o);

    // R2
    ack_one_cycle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        bus_ack_o |=> !bus_ack_o);

    // R2
    ack_needs_stb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !bus_stb_i |=> !bus_ack_o);

    // R9
    tick_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        tick |-> (gap == TICK_DIV - 1));

    generate
        for (genvar g = 0; g < LED_COUNT; g++) begin : g_led
            // R4
            on_lit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (cfg[g].mode == LED_ON) |-> (led_o[g] == ACTIVE_HIGH));

            // R5
            off_dark_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (cfg[g].mode == LED_OFF || cfg[g].mode == LED_RSVD) |-> (led_o[g] == !ACTIVE_HIGH));

            // R6
            toggle_on_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                (cfg[g].mode == LED_BLINK && !$stable(led_o[g]) && !$past(wr_hit[g])) |-> $past(tick));

            // R8
            restart_dark_chk: assert property (@(posedge clk_i) disable iff (rst_i)
                ($past(wr_hit[g]) && cfg[g].mode == LED_BLINK) |-> (led_o[g] == !ACTIVE_HIGH));
        end
    endgenerate
endmodule

bind led_blink_client led_blink_client_chk #(
    .TICK_DIV    (TICK_DIV),
    .ACTIVE_HIGH (ACTIVE_HIGH)
) u_chk (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .bus_stb_i (bus_stb_i),
    .bus_ack_o (bus_ack_o),
    .tick      (tick),
    .cfg       (cfg),
    .wr_hit    (wr_hit),
    .led_o     (led_o)
);

// File: tb/led_blink_client_tb.sv
`timescale 1ns/1ps
module led_blink_client_tb;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  adr = '0;
    logic [31:0] wdat = '0;
    logic        we = 1'b0;
    logic        stb = 1'b0;
    logic        ack, ack_n;
    logic [31:0] rdat, rdat_n;
    logic [3:0]  led, led_n;

    always #2 clk = ~clk;

    led_blink_client #(.CLK_FREQ_HZ(400), .TICK_FREQ_HZ(100), .ACTIVE_HIGH(1'b1)) u_dut (
        .clk_i(clk), .rst_i(rst), .bus_adr_i(adr), .bus_dat_i(wdat), .bus_we_i(we),
        .bus_stb_i(stb), .bus_ack_o(ack), .bus_dat_o(rdat), .led_o(led));

    led_blink_client #(.CLK_FREQ_HZ(400), .TICK_FREQ_HZ(100), .ACTIVE_HIGH(1'b0)) u_dut_n (
        .clk_i(clk), .rst_i(rst), .bus_adr_i(adr), .bus_dat_i(wdat), .bus_we_i(we),
        .bus_stb_i(stb), .bus_ack_o(ack_n), .bus_dat_o(rdat_n), .led_o(led_n));

    typedef struct {
        longint      due;
        bit          rd;
        logic [31:0] data;
        string       tag;
    } xfer_t;

    xfer_t       sb_q[$];
    int          n_checks = 0;
    int          n_errors = 0;
    longint      cyc = 0;
    bit          done = 1'b0;
    string       phase_tag = "R1";
    logic [1:0]  m_mode [4];
    int          m_half [4];
    longint      m_wr   [4];

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_mode[i] = 2'b00; m_half[i] = 0; m_wr[i] = 0;
        end
    end

    always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s (%s) cyc=%0d actual=%h expected=%h", tag, phase_tag, cyc, act, exp);
        end
    endtask

    function automatic bit exp_lit(input int i, input longint c);
        longint t;
        int     h;
        case (m_mode[i])
            2'b01: return 1'b1;
            2'b10: begin
                t = c / DIV - m_wr[i] / DIV;
                h = (m_half[i] == 0) ? 1 : m_half[i];
                return ((t / h) % 2) == 1;
            end
            default: return 1'b0;
        endcase
    endfunction

    function automatic string mode_tag(input int i);
        if (m_mode[i] == 2'b01) return "R4";
        if (m_mode[i] != 2'b10) return "R5";
        if (m_half[i] == 0)     return "R7";
        if (m_half[i] == 1)     return "R9";
        return "R6";
    endfunction

    // Driver: one transfer, queues its expected acknowledge and data
    task automatic bus_xfer(input bit w, input int a, input logic [31:0] d,
                            input logic [31:0] exp, input string tag);
        xfer_t it;
        @(negedge clk);
        stb = 1'b1; we = w; adr = 2'(a); wdat = d;
        @(posedge clk);
        it.due = cyc + 1; it.rd = !w; it.data = exp; it.tag = tag;
        sb_q.push_back(it);
        if (w) begin
            m_mode[a] = d[1:0];
            m_half[a] = int'(d[31:16]);
            m_wr[a]   = cyc + 1;
        end
        @(negedge clk);
        stb = 1'b0; we = 1'b0;
    endtask

    // Monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (ack) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R2", {31'd0, ack}, 32'd0);
                end else begin
                    xfer_t it;
                    it = sb_q.pop_front();
                    check(cyc == it.due, "R2", 32'(cyc), 32'(it.due));
                    if (it.rd) check(rdat == it.data, it.tag, rdat, it.data);
                end
            end else if (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
                void'(sb_q.pop_front());
                check(1'b0, "R2", 32'd0, 32'd1);
            end
            for (int i = 0; i < 4; i++) begin
                bit e;
                e = exp_lit(i, cyc);
                check(led[i] == e, mode_tag(i), {31'd0, led[i]}, {31'd0, e});
                check(led_n[i] == !e, "R10", {31'd0, led_n[i]}, {31'd0, !e});
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(posedge clk);
        // R1: outputs while reset is held
        @(negedge clk);
        check(led == 4'h0, "R1", {28'd0, led}, 32'h0);
        check(led_n == 4'hF, "R1", {28'd0, led_n}, 32'hF);
        check(ack == 1'b0, "R1", {31'd0, ack}, 32'h0);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) bus_xfer(1'b0, i, 32'h0, 32'h0, "R1");

        phase_tag = "R3";
        bus_xfer(1'b1, 0, 32'h0000_0001, 32'h0, "R4");
        bus_xfer(1'b1, 1, 32'h0003_ABCE, 32'h0, "R6");
        bus_xfer(1'b1, 2, 32'h0000_0002, 32'h0, "R7");
        bus_xfer(1'b1, 3, 32'h0009_0003, 32'h0, "R5");
        idle(40);
        bus_xfer(1'b0, 1, 32'h0, 32'h0003_0002, "R3");
        bus_xfer(1'b0, 3, 32'h0, 32'h0009_0003, "R3");
        bus_xfer(1'b0, 2, 32'h0, 32'h0000_0002, "R3");

        phase_tag = "R9";
        bus_xfer(1'b1, 0, 32'h0001_0002, 32'h0, "R9");
        idle(37);

        phase_tag = "R8";
        for (int k = 0; k < 4; k++) begin
            idle(5 + k * 3);
            bus_xfer(1'b1, 1, 32'h0003_0002, 32'h0, "R8");
        end
        idle(30);

        phase_tag = "R11";
        for (int k = 0; k < 6; k++) begin
            bus_xfer(1'b1, 2, (k % 2 == 0) ? 32'h0000_0001 : 32'h0005_0002, 32'h0, "R11");
            idle(7);
        end
        bus_xfer(1'b1, 3, 32'h0000_0000, 32'h0, "R5");
        idle(10);

        phase_tag = "R12";
        for (int k = 0; k < 5; k++) begin
            bus_xfer(1'b0, 1, 32'h0, 32'h0003_0002, "R12");
            bus_xfer(1'b0, 0, 32'h0, 32'h0001_0002, "R12");
            idle(3);
        end
        idle(40);

        done = 1'b1;
        check(sb_q.size() == 0, "R2", 32'(sb_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1'b1;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog (%s) actual=timeout expected=finish", phase_tag);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule